// File: doc/BRIEF.md
# Distance-Based TLB Miss Prefetcher

This block watches the virtual page numbers of TLB misses reported by several cores and guesses which page each core will miss on next. For every core it remembers the page of the last miss and the signed step from the miss before that. A single table, shared by all cores, links each step to the step that came right after it the last time it was seen. When a new miss arrives, the block trains the table with the (previous step, current step) pair. It also looks up the current step. On a hit it issues a prefetch request for the current page plus the remembered follow-on step.

Because the table is shared, a core can use a pattern that another core trained. Two cores walking the same sequence at a fixed page offset from each other both benefit. Page walks for the prefetched pages and the storage of the resulting translations belong to other blocks. This one only produces the request stream.

Top module: `tlb_dist_prefetcher`

## Requirements
- R1: After reset no prefetch is issued, every core's history is empty and every table entry is invalid, so patterns trained before reset cause no prefetch afterwards.
- R2: The first miss of a core after reset only stores its page number and issues no prefetch.
- R3: The second miss of a core only stores the step (current page minus stored page, modulo 2^VPN_W). It performs no lookup and issues no prefetch.
- R4: Every later miss writes the pair (previous step, current step) into the table entry selected by the low log2(TABLE_DEPTH) bits of the previous step. The full previous step is the tag, and the write replaces whatever the entry held.
- R5: Every later miss also reads the entry selected by the low bits of the current step. If that entry is valid and its tag equals the current step, a prefetch is issued for page = current page + stored next step, modulo 2^VPN_W.
- R6: If the selected entry holds a different step with the same low index bits, no prefetch is issued.
- R7: A prefetch appears on pf_valid exactly one cycle after the miss strobe that triggered it and carries that miss's core ID. In every other cycle pf_valid is low.
- R8: A lookup sees the table as it was before the training write of the same miss, so a miss never predicts from the pair it is writing.
- R9: Each core's page and step history is changed only by misses carrying that core's ID, including when misses from different cores arrive on back-to-back cycles.
- R10: Pairs trained by one core's misses produce prefetches for another core whose steps match.
- R11: Negative steps (descending page sequences) train and predict like positive ones.
- R12: The miss sequence 1,2,4,5,7,8 on one core yields prefetches for pages 7, 8 and 10, triggered by the misses on 5, 7 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal two-stage synchronizer |
| miss_valid | input | 1 | A TLB miss is reported this cycle |
| miss_core | input | CORE_W | ID of the core that missed |
| miss_vpn | input | VPN_W | Virtual page number of the miss |
| pf_valid | output | 1 | A prefetch request is presented this cycle |
| pf_core | output | CORE_W | Core the prefetch is meant for |
| pf_vpn | output | VPN_W | Predicted virtual page number |

## Verification
The bench exposes the first two misses of each core. A design that looked up too early would emit a prefetch on the second miss, and one that trained too early would predict from a stale step. It drives a descending walk with a constant step of one. A design that read the table after its own write would issue a prefetch on the third miss instead of the fourth. The bench also forces two steps, 1 and 513, to share an index. A design that compared only the index bits would issue a prefetch where none is due. Interleaved back-to-back misses from two cores and a reset between scenarios show whether history leaks between cores or survives reset. Either fault would produce wrong addresses or spurious requests.

// File: rtl/tlbpf_pkg.sv
package tlbpf_pkg;

  // Training state of one core's miss history.
  typedef enum logic [1:0] {
    HIST_EMPTY = 2'd0,  // nothing recorded
    HIST_PAGE  = 2'd1,  // a page is held, no step yet
    HIST_STEP  = 2'd2   // page and step held: train and look up
  } hist_phase_e;

endpackage

// File: rtl/tlbpf_core_hist.sv
module tlbpf_core_hist
  import tlbpf_pkg::*;
#(
  parameter int VPN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [VPN_W-1:0] miss_vpn,
  input  logic [VPN_W-1:0] new_step,
  output hist_phase_e      phase_q,
  output logic [VPN_W-1:0] last_vpn_q,
  output logic [VPN_W-1:0] last_step_q
);

  hist_phase_e      phase_d;
  logic             step_en;

  always_comb begin
    phase_d = phase_q;
    step_en = 1'b0;
    if (upd_en) begin
      unique case (phase_q)
        HIST_EMPTY: phase_d = HIST_PAGE;
        HIST_PAGE: begin
          phase_d = HIST_STEP;
          step_en = 1'b1;
        end
        default: begin
          phase_d = HIST_STEP;
          step_en = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= HIST_EMPTY;
    else        phase_q <= phase_d;
  end

  always_ff @(posedge clk) begin
    if (upd_en)  last_vpn_q  <= miss_vpn;
    if (step_en) last_step_q <= new_step;
  end

  // R2
  first_miss_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && phase_q == HIST_EMPTY) |=> (phase_q == HIST_PAGE && last_vpn_q == $past(miss_vpn)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> ($stable(phase_q) && $stable(last_vpn_q)));

endmodule

// File: rtl/tlbpf_step_table.sv
module tlbpf_step_table #(
  parameter int STEP_W = 20,
  parameter int DEPTH  = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [STEP_W-1:0] wr_key,
  input  logic [STEP_W-1:0] wr_next,
  input  logic [STEP_W-1:0] rd_key,
  output logic              rd_hit,
  output logic [STEP_W-1:0] rd_next
);

  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0]  vld_q;
  logic [STEP_W-1:0] tag_q [DEPTH];
  logic [STEP_W-1:0] nxt_q [DEPTH];
  logic [IDX_W-1:0]  wr_idx;
  logic [IDX_W-1:0]  rd_idx;

  assign wr_idx = wr_key[IDX_W-1:0];
  assign rd_idx = rd_key[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_key;
      nxt_q[wr_idx] <= wr_next;
    end
  end

  // Read returns contents from before this cycle's write.
  always_comb begin
    rd_hit  = vld_q[rd_idx] && (tag_q[rd_idx] == rd_key);
    rd_next = nxt_q[rd_idx];
  end

  // R4
  train_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && rd_key == $past(wr_key)) |-> (rd_hit && rd_next == $past(wr_next)));

  // R6
  alias_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && rd_idx == $past(wr_idx) && rd_key != $past(wr_key)) |-> !rd_hit);

endmodule

// File: rtl/tlb_dist_prefetcher.sv
module tlb_dist_prefetcher
  import tlbpf_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int VPN_W       = 20,
  parameter int TABLE_DEPTH = 512,
  localparam int CORE_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [CORE_W-1:0] miss_core,
  input  logic [VPN_W-1:0]  miss_vpn,
  output logic              pf_valid,
  output logic [CORE_W-1:0] pf_core,
  output logic [VPN_W-1:0]  pf_vpn
);

  // Asynchronous assert, synchronous release.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  hist_phase_e      phase_arr [NUM_CORES];
  logic [VPN_W-1:0] lvpn_arr  [NUM_CORES];
  logic [VPN_W-1:0] lstep_arr [NUM_CORES];
  logic [VPN_W-1:0] cur_step;

  for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_core
    logic upd_en;
    assign upd_en = miss_valid && (miss_core == CORE_W'(gi));
    tlbpf_core_hist #(.VPN_W(VPN_W)) u_hist (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .upd_en      (upd_en),
      .miss_vpn    (miss_vpn),
      .new_step    (cur_step),
      .phase_q     (phase_arr[gi]),
      .last_vpn_q  (lvpn_arr[gi]),
      .last_step_q (lstep_arr[gi])
    );
  end

  hist_phase_e      sel_phase;
  logic [VPN_W-1:0] sel_vpn;
  logic [VPN_W-1:0] sel_step;
  logic             learn_go;
  logic             rd_hit;
  logic [VPN_W-1:0] rd_next;

  always_comb begin
    sel_phase = phase_arr[miss_core];
    sel_vpn   = lvpn_arr[miss_core];
    sel_step  = lstep_arr[miss_core];
    cur_step  = miss_vpn - sel_vpn;
    learn_go  = miss_valid && (sel_phase == HIST_STEP);
  end

  tlbpf_step_table #(.STEP_W(VPN_W), .DEPTH(TABLE_DEPTH)) u_table (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (learn_go),
    .wr_key  (sel_step),
    .wr_next (cur_step),
    .rd_key  (cur_step),
    .rd_hit  (rd_hit),
    .rd_next (rd_next)
  );

  // Output register: next-state, then flops.
  logic              pf_valid_d;
  logic [VPN_W-1:0]  pf_vpn_d;

  always_comb begin
    pf_valid_d = learn_go && rd_hit;
    pf_vpn_d   = miss_vpn + rd_next;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pf_valid <= 1'b0;
    else             pf_valid <= pf_valid_d;
  end

  always_ff @(posedge clk) begin
    if (pf_valid_d) begin
      pf_core <= miss_core;
      pf_vpn  <= pf_vpn_d;
    end
  end

  // R7
  pf_follows_miss_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pf_valid |-> $past(miss_valid));

  // R7
  pf_core_match_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pf_valid |-> (pf_core == $past(miss_core)));

  // R3
  no_early_pf_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pf_valid |-> ($past(sel_phase) == HIST_STEP));

endmodule

// File: tb/tlb_dist_prefetcher_tb.sv
module tlb_dist_prefetcher_tb;

  localparam int NC = 4;
  localparam int VW = 20;
  localparam int CW = 2;

  logic          clk;
  logic          rst_n;
  logic          miss_valid;
  logic [CW-1:0] miss_core;
  logic [VW-1:0] miss_vpn;
  logic          pf_valid;
  logic [CW-1:0] pf_core;
  logic [VW-1:0] pf_vpn;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  typedef struct {
    int            at;
    bit            v;
    logic [VW-1:0] vpn;
    int            core;
    string         req;
  } exp_t;

  exp_t q[$];

  tlb_dist_prefetcher #(.NUM_CORES(NC), .VPN_W(VW), .TABLE_DEPTH(512)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .miss_core  (miss_core),
    .miss_vpn   (miss_vpn),
    .pf_valid   (pf_valid),
    .pf_core    (pf_core),
    .pf_vpn     (pf_vpn)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare outputs against queued expectations.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0 && q[0].at == cyc) begin
        exp_t e;
        e = q.pop_front();
        tests++;
        if (pf_valid !== e.v || (e.v && (pf_vpn !== e.vpn || int'(pf_core) != e.core))) begin
          fails++;
          $display("FAIL %s: got v=%0b vpn=%0d core=%0d, expected v=%0b vpn=%0d core=%0d",
                   e.req, pf_valid, pf_vpn, pf_core, e.v, e.vpn, e.core);
        end
      end else if (pf_valid === 1'b1) begin
        tests++;
        fails++;
        $display("FAIL R7: got unexpected prefetch vpn=%0d core=%0d, expected none",
                 pf_vpn, pf_core);
      end
    end
  end

  // Driver: one miss per cycle; expectation lands one cycle later.
  task automatic miss(input int core, input int vpn, input bit ev, input int evpn,
                      input string req);
    exp_t e;
    miss_valid = 1'b1;
    miss_core  = CW'(core);
    miss_vpn   = VW'(vpn);
    e.at   = cyc + 1;
    e.v    = ev;
    e.vpn  = VW'(evpn);
    e.core = core;
    e.req  = req;
    q.push_back(e);
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    miss_valid = 1'b0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    tests++;
    if (pf_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: got pf_valid=%0b after reset, expected 0", pf_valid);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    miss_valid = 1'b0;
    miss_core  = '0;
    miss_vpn   = '0;
    rst_n      = 1'b0;
    @(negedge clk);
    do_reset();

    // R12 / R2 / R3 / R4 / R5: pages 1,2,4,5,7,8 on core 0
    miss(0, 1, 0, 0, "R2");
    miss(0, 2, 0, 0, "R3");
    miss(0, 4, 0, 0, "R4");
    miss(0, 5, 1, 7, "R12");
    idle(2);
    miss(0, 7, 1, 8, "R12");
    miss(0, 8, 1, 10, "R5");
    idle(2);

    // R10: core 1 walks the same pattern at an offset of 4 pages
    miss(1, 5, 0, 0, "R2");
    miss(1, 6, 0, 0, "R3");
    miss(1, 8, 1, 9, "R10");
    miss(1, 9, 1, 11, "R10");
    idle(3);

    // R1: reset wipes histories and table
    do_reset();
    miss(0, 1, 0, 0, "R1");
    miss(0, 2, 0, 0, "R1");
    miss(0, 4, 0, 0, "R1");
    idle(2);

    // R11 / R8: descending walk, constant step -1 on core 2
    do_reset();
    miss(2, 100, 0, 0, "R11");
    miss(2, 99, 0, 0, "R11");
    miss(2, 98, 0, 0, "R8");
    miss(2, 97, 1, 96, "R11");
    idle(2);

    // R6: steps 1 and 513 share index 1
    do_reset();
    miss(0, 0, 0, 0, "R2");
    miss(0, 1, 0, 0, "R3");
    miss(0, 3, 0, 0, "R4");
    miss(0, 516, 0, 0, "R6");
    miss(0, 517, 1, 519, "R5");
    miss(0, 518, 0, 0, "R6");
    idle(2);

    // R9: interleaved back-to-back misses on cores 0 and 3
    do_reset();
    miss(0, 10, 0, 0, "R9");
    miss(3, 200, 0, 0, "R9");
    miss(0, 11, 0, 0, "R9");
    miss(3, 202, 0, 0, "R9");
    miss(0, 13, 0, 0, "R9");
    miss(3, 206, 0, 0, "R9");
    miss(0, 14, 1, 16, "R9");
    miss(3, 208, 1, 209, "R9");
    idle(4);

    tests++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R7: got %0d unchecked expectations, expected 0", q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule